// File: doc/BRIEF.md
# I2C Read-Only Slave with Last-Byte Interrupt

This block is the transmit side of an I2C target. Local logic pushes outbound bytes into a small internal queue. While the queue holds data and the bus is idle, an active-low interrupt line tells the bus controller that data is waiting. The controller then issues a START and a read to the block's 7-bit address. The block answers with the queued bytes, most significant bit first.

The interrupt line also marks the end of the data. It stays low while more bytes remain. It rises on the SCL falling edge that closes bit 0 of the final queued byte, and it stays high through the following acknowledge clock. The controller checks the line in the low phase just before its acknowledge clock. If the line is low, the controller acknowledges and reads again. If it is high, the controller answers with NACK and then STOP. No length field is exchanged. Every queued byte has to be taken in a single transaction: a NACK, or a START or STOP during the data phase, discards whatever is still queued.

SCL and SDA arrive asynchronously and pass through flip-flop synchronisers. SDA is driven open-drain through an output enable.

Top module: `i2c_rdq_slave`

## Requirements
- R1: While `en` is low, `irq_n` is high from the next clock edge and the block does not acknowledge its address. Bytes pushed meanwhile are kept. After reset `irq_n` is high and `sda_oe` is low.
- R2: With the bus idle and `en` high, `irq_n` is low from the clock edge that accepts a push, or whenever the queue is non-empty. It is high when the queue is empty.
- R3: The block acknowledges (SDA low during the ninth clock) only an address byte whose upper 7 bits equal `SLV_ADDR` and whose bit 0 (R/W) is 1. Any other address byte is left unacknowledged, and no data is driven until the next START.
- R4: Data bytes leave in push order, most significant bit first. A byte requested while the queue is empty reads as 0xFF.
- R5: `sda_oe` changes only while the synchronised SCL is low.
- R6: Once low during a read, `irq_n` stays low at least until the SCL falling edge of bit 0 of the final queued byte. In particular it is low while SCL is high for that bit.
- R7: If the queue is empty at that falling edge, `irq_n` goes high. It then stays high through the SCL high phase of the acknowledge clock.
- R8: A controller ACK (SDA low on the ninth rising SCL edge) starts the next byte. A NACK ends the transfer.
- R9: A NACK, or a START or STOP seen after the address was acknowledged, empties the queue, so `irq_n` is high once the bus is idle again.
- R10: A byte pushed while a byte is being sent, before its bit-0 falling edge, keeps `irq_n` low and is sent next in the same transaction.
- R11: A push while the queue already holds `DEPTH` bytes is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enables the interrupt line and address response |
| push_valid | input | 1 | Pushes `push_data` into the outbound queue |
| push_data | input | 8 | Byte to queue |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq_n | output | 1 | Active-low data-pending / last-byte indication |

## Verification
The bench builds the block with `DEPTH` = 4, `SLV_ADDR` = 0x35 and two synchroniser stages. With a queue this small, every fill level from one to four can be crossed with every point at which the controller stops reading. That sweep covers the in-order data path, the final-byte interrupt edge, early-NACK flushing and the hold window around the acknowledge clock. The small depth also makes overflow reachable with a few pushes. Separate runs cover the disabled state, address and direction mismatches, reads from an empty queue, and a push that lands in the middle of a transfer.

// File: rtl/i2c_rdq_pkg.sv
package i2c_rdq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // bus idle, interrupt follows the queue
    ST_ADDR = 3'd1,  // shifting in the address byte
    ST_AACK = 3'd2,  // driving the address acknowledge
    ST_TX   = 3'd3,  // shifting a data byte out
    ST_DACK = 3'd4,  // waiting for the controller ACK/NACK
    ST_ACKD = 3'd5,  // ACK seen, next byte loads on SCL fall
    ST_SKIP = 3'd6   // not addressed or finished, wait for START/STOP
  } rd_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/i2c_rdq_rstsync.sv
module i2c_rdq_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] rst_pipe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign srst_n = rst_pipe[1];

endmodule

// File: rtl/i2c_rdq_sync.sv
module i2c_rdq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rdq_fifo.sv
module i2c_rdq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         push_ok
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n;
  logic [AW-1:0] rd_ptr, rd_ptr_n;
  logic [CW-1:0] count, count_n;
  logic          pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push_ok) wr_ptr_n = ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr_n = ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_n = count + 1'b1;
        2'b01:   count_n = count - 1'b1;
        default: count_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/i2c_rdq_slave.sv
module i2c_rdq_slave
  import i2c_rdq_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR    = 7'h35,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       irq_n
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic srst_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] fifo_dout;
  logic fifo_empty, fifo_full, push_ok;

  rd_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              irq_q, irq_n_nxt;
  logic              load_evt, flush_evt, data_phase, last_fall, pending;

  i2c_rdq_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  i2c_rdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (srst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rdq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (srst_n),
    .push    (push_valid),
    .din     (push_data),
    .pop     (load_evt),
    .flush   (flush_evt),
    .dout    (fifo_dout),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .push_ok (push_ok)
  );

  assign data_phase = (st_q == ST_AACK) || (st_q == ST_TX) ||
                      (st_q == ST_DACK) || (st_q == ST_ACKD);
  assign last_fall  = (st_q == ST_TX) && scl_fall && (cnt_q == CNT_LAST);
  assign pending    = ~fifo_empty | push_ok;

  // protocol next state
  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    load_evt  = 1'b0;
    flush_evt = 1'b0;
    if (stop_evt) begin
      st_n      = ST_IDLE;
      flush_evt = data_phase;
    end else if (start_evt) begin
      st_n      = ST_ADDR;
      cnt_n     = '0;
      flush_evt = data_phase;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && (cnt_q != CNT_FULL)) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_FULL)) begin
            if (en && (sh_q[7:1] == SLV_ADDR) && sh_q[0]) st_n = ST_AACK;
            else                                          st_n = ST_SKIP;
          end
        end
        ST_AACK, ST_ACKD: begin
          if (scl_fall) begin
            st_n     = ST_TX;
            load_evt = 1'b1;
            cnt_n    = '0;
            sh_n     = fifo_empty ? FILL_BYTE : fifo_dout;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_n = ST_DACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b1};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_DACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              st_n = ST_ACKD;
            end else begin
              st_n      = ST_SKIP;
              flush_evt = 1'b1;
            end
          end
        end
        default: st_n = st_q;
      endcase
    end
  end

  // interrupt next state
  always_comb begin
    irq_n_nxt = irq_q;
    if (!en)                  irq_n_nxt = 1'b1;
    else if (st_q == ST_IDLE) irq_n_nxt = ~pending;
    else if (last_fall)       irq_n_nxt = ~pending;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '1;
      irq_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      irq_q <= irq_n_nxt;
    end
  end

  assign irq_n  = irq_q;
  assign sda_oe = (st_q == ST_AACK) || ((st_q == ST_TX) && !sh_q[BYTE_W-1]);

endmodule

// File: rtl/i2c_rdq_chk.sv
module i2c_rdq_chk
  import i2c_rdq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      en,
  input logic      scl_s,
  input logic      scl_fall,
  input logic      sda_oe,
  input logic      irq_n,
  input rd_state_e st,
  input logic      fifo_full,
  input logic      push_valid,
  input logic      pop,
  input logic      flush
);

  // R1: disabled means the interrupt is inactive on the next edge
  a_r1_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> irq_n);

  // R5: the data line only changes while SCL is low
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R6: a low interrupt is held while a byte is shifted and SCL has not fallen
  a_r6_irq_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_TX && !irq_n && !scl_fall) |=> !irq_n);

  // R7: a high interrupt is held across the acknowledge clock
  a_r7_irq_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_DACK && irq_n) |=> irq_n);

  // R11: a push into a full queue leaves it full
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && push_valid && !pop && !flush) |=> fifo_full);

endmodule

bind i2c_rdq_slave i2c_rdq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .scl_s      (scl_s),
  .scl_fall   (scl_fall),
  .sda_oe     (sda_oe),
  .irq_n      (irq_n),
  .st         (st_q),
  .fifo_full  (fifo_full),
  .push_valid (push_valid),
  .pop        (load_evt),
  .flush      (flush_evt)
);

// File: tb/i2c_rdq_slave_tb.sv
`timescale 1ns/1ps
module i2c_rdq_slave_tb;

  localparam logic [6:0] ADDR  = 7'h35;
  localparam int         DEPTH = 4;
  localparam int         H     = 10;  // half SCL period in system clocks
  localparam int         Q     = 4;   // hold after SCL fall

  logic clk = 1'b0;
  logic rst_n, en, push_valid, scl_m, sda_m;
  logic [7:0] push_data;
  logic sda_oe, irq_n;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_rdq_slave #(.SLV_ADDR(ADDR), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .push_valid (push_valid),
    .push_data  (push_data),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe     (sda_oe),
    .irq_n      (irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] val(input logic [7:0] base, input int j);
    return base + 8'(j * 7);
  endfunction

  task automatic push_run(input logic [7:0] base, input int cnt);
    for (int j = 0; j < cnt; j++) begin
      @(negedge clk);
      push_valid = 1'b1;
      push_data  = val(base, j);
      @(negedge clk);
      push_valid = 1'b0;
      if (j == 0 && en) chk("R2 irq low after push", irq_n, 1'b0);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(H);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic get_bit(output logic b, output logic irq_hi);
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H / 2);
    b = sda_bus; irq_hi = irq_n;
    wclk(H / 2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_addr(input logic [7:0] abyte, output logic ack);
    logic dmy;
    for (int i = 7; i >= 0; i--) put_bit(abyte[i]);
    get_bit(ack, dmy);
  endtask

  task automatic get_byte(output logic [7:0] v, output logic irq_b0);
    logic b, ih;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, ih);
      v[i] = b;
    end
    irq_b0 = ih;
  endtask

  // controller ACK slot: returns irq seen in the low phase and the high phase
  task automatic ack_slot(input logic more, output logic irq_lo, output logic irq_hi);
    wclk(H);
    irq_lo = irq_n;
    sda_m = more ? 1'b0 : 1'b1;
    wclk(2);
    scl_m = 1'b1; wclk(H / 2);
    irq_hi = irq_n;
    wclk(H / 2);
    scl_m = 1'b0; wclk(Q);
    sda_m = 1'b1;
  endtask

  // read 'take' bytes when 'avail' are queued; controller ends after 'take'
  task automatic do_read(input int avail, input int take, input logic [7:0] base);
    logic ack, ib0, ilo, ihi;
    logic [7:0] v, e;
    i2c_start;
    send_addr({ADDR, 1'b1}, ack);
    chk("R3 address ack", ack, 1'b0);
    for (int j = 0; j < take; j++) begin
      get_byte(v, ib0);
      e = (j < avail) ? val(base, j) : 8'hFF;
      chk("R4 byte value", v, e);
      chk("R6 irq at last bit high phase", ib0, (j < avail) ? 1'b0 : 1'b1);
      ack_slot(j < take - 1, ilo, ihi);
      chk("R7 irq before ack", ilo, (j >= avail - 1) ? 1'b1 : 1'b0);
      chk("R7 irq hold in ack", ihi, (j >= avail - 1) ? 1'b1 : 1'b0);
    end
    i2c_stop;
    wclk(4);
    chk((take < avail) ? "R9 flushed after nack" : "R8 idle after final nack", irq_n, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack, ib0, ilo, ihi;
    logic [7:0] v;
    rst_n = 1'b0; en = 1'b0; push_valid = 1'b0; push_data = 8'h00;
    scl_m = 1'b1; sda_m = 1'b1;
    wclk(5);
    chk("R1 reset irq", irq_n, 1'b1);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    rst_n = 1'b1;
    wclk(6);

    // R1: disabled keeps irq high and ignores its address
    push_run(8'h40, 1);
    wclk(2);
    chk("R1 irq high while disabled", irq_n, 1'b1);
    i2c_start;
    send_addr({ADDR, 1'b1}, ack);
    chk("R1 no ack while disabled", ack, 1'b1);
    i2c_stop;
    en = 1'b1;
    wclk(2);
    chk("R2 irq low after enable", irq_n, 1'b0);
    do_read(1, 1, 8'h40);

    // R3: wrong address and write direction are not acknowledged
    push_run(8'h90, 2);
    i2c_start;
    send_addr({ADDR ^ 7'h01, 1'b1}, ack);
    chk("R3 wrong address no ack", ack, 1'b1);
    i2c_stop;
    i2c_start;
    send_addr({ADDR, 1'b0}, ack);
    chk("R3 write direction no ack", ack, 1'b1);
    i2c_stop;
    wclk(4);
    chk("R3 irq still pending", irq_n, 1'b0);
    do_read(2, 2, 8'h90);

    // sweep fill level against the byte at which the controller stops
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 1; k <= n; k++) begin
        push_run(8'(n * 32 + k * 5), n);
        do_read(n, k, 8'(n * 32 + k * 5));
      end
    end

    // R4: empty queue reads as fill bytes
    chk("R2 irq high when empty", irq_n, 1'b1);
    do_read(0, 2, 8'h00);

    // R11: overflow drops the extra pushes
    push_run(8'h10, DEPTH + 2);
    do_read(DEPTH, DEPTH, 8'h10);

    // R10: a push during a byte extends the transfer
    push_run(8'hA0, 1);
    i2c_start;
    send_addr({ADDR, 1'b1}, ack);
    chk("R3 address ack", ack, 1'b0);
    @(negedge clk); push_valid = 1'b1; push_data = 8'h5C;
    @(negedge clk); push_valid = 1'b0;
    get_byte(v, ib0);
    chk("R10 first byte", v, 8'hA0);
    ack_slot(1'b1, ilo, ihi);
    chk("R10 irq stays low after extension", ilo, 1'b0);
    get_byte(v, ib0);
    chk("R10 pushed byte sent next", v, 8'h5C);
    ack_slot(1'b0, ilo, ihi);
    chk("R10 irq high after last", ilo, 1'b1);
    i2c_stop;
    wclk(4);
    chk("R10 idle irq", irq_n, 1'b1);

    // R1: disable with data pending forces irq high
    push_run(8'h22, 1);
    en = 1'b0;
    wclk(2);
    chk("R1 disable raises irq", irq_n, 1'b1);
    en = 1'b1;
    wclk(2);
    chk("R2 re-enable lowers irq", irq_n, 1'b0);
    do_read(1, 1, 8'h22);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule